// File: doc/BRIEF.md
# Three-Phase RMS Voltage Sag Detector

This block watches the RMS voltage of three supply phases, each of which delivers one new RMS word per line cycle together with a one-cycle strobe. For every phase it counts how many consecutive line cycles the reading has stayed under a programmable level. When that run reaches a programmable length, the block raises a sticky sag flag for the phase. The level is given in the format of the upper 16 bits of the raw RMS word, and the comparison uses only those bits.

Flags stay set until the host clears them through a write-to-clear strobe that carries a per-phase mask. Each flag has its own interrupt enable. One registered interrupt line is the OR of the enabled flags. A run length of zero turns detection off.

Each phase runs a small tracker state machine. Its states are `TRK_IDLE`, `TRK_RUN` and `TRK_HIT`:
- `TRK_IDLE`: no low run is in progress and the counter is zero.
- `TRK_RUN`: a low run is being counted.
- `TRK_HIT`: the run has reached the programmed length.

The transitions are as follows:
- **start:** `TRK_IDLE` goes to `TRK_RUN` on a low strobe.
- **hit:** any state goes to `TRK_HIT` on the low strobe that brings the count to the limit.
- **recover:** `TRK_RUN` or `TRK_HIT` goes to `TRK_IDLE` on a strobe whose reading is not low.
- **hold:** with no strobe, the state stays where it is.

Top module: `sag_detector`

## Requirements
- R1: During reset and in the first cycle after it, all three flags and the interrupt are 0.
- R2: A reading counts as low only when RMS bits [23:8], taken as unsigned, are strictly below the 16-bit threshold. An equal value is not low, and bits [7:0] have no effect.
- R3: A phase's flag is set on the edge that samples the strobe at which its count of consecutive low strobes first equals the programmed length. The flag is visible in the next cycle and never earlier.
- R4: A strobe whose reading is not low resets that phase's run count to zero. Later detection then needs a full new run.
- R5: A programmed length of 0 never sets any flag.
- R6: A set flag stays set through any readings until a host clear or a reset.
- R7: A clear strobe with mask bit i = 1 clears flag i (bit 0 = A, 1 = B, 2 = C) on that edge and leaves the other flags unchanged.
- R8: If a clear of a phase and a new detection on that phase happen on the same edge, the flag ends up set.
- R9: After a clear during an unbroken low run that has already reached the length, further low strobes do not set the flag again.
- R10: The interrupt equals the OR over phases of (flag AND enable), registered one cycle later. Enable bit positions match the flag bits.
- R11: Each phase is counted only on its own strobe. Cycles without a strobe leave that phase's count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rms_a_i | input | 24 | Raw RMS word, phase A |
| rms_b_i | input | 24 | Raw RMS word, phase B |
| rms_c_i | input | 24 | Raw RMS word, phase C |
| cyc_strobe_i | input | 3 | Line-cycle strobe per phase (bit 0 = A) |
| sag_thresh_i | input | 16 | Sag level, compared with RMS bits [23:8] |
| sag_cycles_i | input | 8 | Required run length in line cycles; 0 disables detection |
| irq_en_i | input | 3 | Interrupt enable per phase |
| clr_stb_i | input | 1 | Host write-to-clear strobe |
| clr_mask_i | input | 3 | Flags to clear when the strobe is high |
| sag_flag_o | output | 3 | Sticky sag flags (bit 0 = A) |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Readings are placed right at the threshold: equal upper bits with any low byte, and one count below with a zero low byte. This separates a strict compare from a non-strict one, and a 16-bit compare from a full-width one. Directed runs that are one strobe short of the length, runs broken by a single high reading, and a length of zero separate correct run counting from off-by-one, non-resetting and always-on counters. Clears that coincide with detection, and clears issued mid-run, distinguish set-priority and re-arm behaviour. A long random phase then mixes per-phase strobes, near-threshold readings, clears and enables against a bench model.

// File: rtl/sag_pkg.sv
package sag_pkg;
    localparam int unsigned NUM_PHASES = 3;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_RUN  = 2'd1,
        TRK_HIT  = 2'd2
    } trk_state_e;
endpackage

// File: rtl/sag_phase_tracker.sv
module sag_phase_tracker
    import sag_pkg::*;
#(
    parameter int unsigned RMS_W = 24,
    parameter int unsigned THR_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [RMS_W-1:0] rms_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             detect_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             below, low_stb, hit;

    // Only the upper THR_W bits of the RMS word take part in the compare.
    assign below   = rms_i[RMS_W-1 -: THR_W] < thresh_i;
    assign low_stb = strobe_i && below;
    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign hit     = low_stb && (limit_i != '0) && (cnt_q != CNT_MAX)
                     && (cnt_inc == limit_i);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (low_stb) begin
                    state_d = hit ? TRK_HIT : TRK_RUN;
                    cnt_d   = cnt_inc;
                end
            end
            TRK_RUN: begin
                if (strobe_i) begin
                    if (!below) begin
                        state_d = TRK_IDLE;
                        cnt_d   = '0;
                    end else begin
                        state_d = hit ? TRK_HIT : TRK_RUN;
                        cnt_d   = cnt_inc;
                    end
                end
            end
            TRK_HIT: begin
                if (strobe_i) begin
                    if (!below) begin
                        state_d = TRK_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_inc;
                    end
                end
            end
            default: begin
                state_d = TRK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        detect_o = hit;
    end
endmodule

// File: rtl/sag_flag_bank.sv
module sag_flag_bank #(
    parameter int unsigned NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] set_i,
    input  logic           clr_stb_i,
    input  logic [NPH-1:0] clr_mask_i,
    input  logic [NPH-1:0] irq_en_i,
    output logic [NPH-1:0] flag_o,
    output logic           irq_o
);
    logic [NPH-1:0] flag_q, clr_vec;
    logic           irq_q;

    assign clr_vec = clr_stb_i ? clr_mask_i : '0;

    // A new detection takes precedence over a clear on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | set_i;
            irq_q  <= |(flag_q & irq_en_i);
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/sag_detector.sv
module sag_detector
    import sag_pkg::*;
#(
    parameter int unsigned RMS_W = 24,
    parameter int unsigned THR_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RMS_W-1:0]      rms_a_i,
    input  logic [RMS_W-1:0]      rms_b_i,
    input  logic [RMS_W-1:0]      rms_c_i,
    input  logic [NUM_PHASES-1:0] cyc_strobe_i,
    input  logic [THR_W-1:0]      sag_thresh_i,
    input  logic [CNT_W-1:0]      sag_cycles_i,
    input  logic [NUM_PHASES-1:0] irq_en_i,
    input  logic                  clr_stb_i,
    input  logic [NUM_PHASES-1:0] clr_mask_i,
    output logic [NUM_PHASES-1:0] sag_flag_o,
    output logic                  irq_o
);
    logic [RMS_W-1:0]      rms_arr [NUM_PHASES];
    logic [NUM_PHASES-1:0] detect;

    assign rms_arr[0] = rms_a_i;
    assign rms_arr[1] = rms_b_i;
    assign rms_arr[2] = rms_c_i;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        sag_phase_tracker #(
            .RMS_W (RMS_W),
            .THR_W (THR_W),
            .CNT_W (CNT_W)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (cyc_strobe_i[p]),
            .rms_i    (rms_arr[p]),
            .thresh_i (sag_thresh_i),
            .limit_i  (sag_cycles_i),
            .detect_o (detect[p])
        );
    end

    sag_flag_bank #(
        .NPH (NUM_PHASES)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (detect),
        .clr_stb_i  (clr_stb_i),
        .clr_mask_i (clr_mask_i),
        .irq_en_i   (irq_en_i),
        .flag_o     (sag_flag_o),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/sag_detector_chk.sv
module sag_detector_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cyc_strobe_i,
    input logic [CNT_W-1:0] sag_cycles_i,
    input logic [2:0]       irq_en_i,
    input logic             clr_stb_i,
    input logic [2:0]       sag_flag_o,
    input logic             irq_o
);
    // R6: without a clear, no flag falls.
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb_i |=> ((sag_flag_o & $past(sag_flag_o)) == $past(sag_flag_o)));

    // R10: the interrupt follows the enabled flags one cycle later.
    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(sag_flag_o) & $past(irq_en_i))));

    // R5: a zero length never raises a flag.
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_cycles_i == '0) |=> ((sag_flag_o & ~$past(sag_flag_o)) == '0));

    // R11: a flag can only rise after its own strobe.
    assert_rise_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sag_flag_o & ~$past(sag_flag_o) & ~$past(cyc_strobe_i)) == '0));

    // R1: reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (sag_flag_o == '0 && irq_o == 1'b0);
        end
    end
endmodule

bind sag_detector sag_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_strobe_i (cyc_strobe_i),
    .sag_cycles_i (sag_cycles_i),
    .irq_en_i     (irq_en_i),
    .clr_stb_i    (clr_stb_i),
    .sag_flag_o   (sag_flag_o),
    .irq_o        (irq_o)
);

// File: tb/sim_sag_detector.sv
`timescale 1ns/1ps
module sim_sag_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] rms_a = '0, rms_b = '0, rms_c = '0;
    logic [2:0]  strobe = '0;
    logic [15:0] thr = 16'h4000;
    logic [7:0]  len = 8'd3;
    logic [2:0]  en = '0;
    logic        clr = 1'b0;
    logic [2:0]  mask = '0;
    logic [2:0]  flags;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int m_cnt [3];
    logic [2:0] m_flag = '0;
    logic       m_irq = 1'b0;

    always #2.5 clk = ~clk;

    sag_detector u0 (
        .clk (clk), .rst_n (rst_n),
        .rms_a_i (rms_a), .rms_b_i (rms_b), .rms_c_i (rms_c),
        .cyc_strobe_i (strobe), .sag_thresh_i (thr), .sag_cycles_i (len),
        .irq_en_i (en), .clr_stb_i (clr), .clr_mask_i (mask),
        .sag_flag_o (flags), .irq_o (irq)
    );

    function automatic bit is_low(logic [23:0] r, logic [15:0] t);
        return r[23:8] < t;
    endfunction

    function automatic logic [23:0] rms_of(int p);
        return (p == 0) ? rms_a : (p == 1) ? rms_b : rms_c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic tick(string req);
        logic [2:0] det;
        logic [2:0] clrv;
        @(posedge clk);
        det = '0;
        for (int p = 0; p < 3; p++) begin
            if (strobe[p]) begin
                if (is_low(rms_of(p), thr)) begin
                    if (m_cnt[p] < 255) begin
                        m_cnt[p]++;
                        if (len != 0 && m_cnt[p] == int'(len)) det[p] = 1'b1;
                    end
                end else begin
                    m_cnt[p] = 0;
                end
            end
        end
        clrv   = clr ? mask : 3'b000;
        m_irq  = |(m_flag & en);
        m_flag = (m_flag & ~clrv) | det;
        @(negedge clk);
        check({req, " flags"}, {29'd0, flags}, {29'd0, m_flag});
        check("R10 irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic idle_inputs();
        strobe = '0; clr = 1'b0; mask = '0;
    endtask

    task automatic strobe_a(logic [23:0] r, string req);
        rms_a = r; strobe = 3'b001; tick(req); idle_inputs();
    endtask

    task automatic do_clear(logic [2:0] m);
        clr = 1'b1; mask = m; tick("R7"); idle_inputs();
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < 3; p++) m_cnt[p] = 0;
        repeat (3) @(negedge clk);
        check("R1 flags in reset", {29'd0, flags}, 32'd0);
        check("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        tick("R1");

        // R2: equal upper bits never count, low byte ignored.
        len = 8'd1; en = 3'b001;
        strobe_a({16'h4000, 8'hFF}, "R2");
        strobe_a({16'h4000, 8'h00}, "R2");
        check("R2 equal not low", {29'd0, flags}, 32'd0);
        strobe_a({16'h3FFF, 8'h00}, "R2");
        check("R2 one below sets", {29'd0, flags}, 32'd1);
        tick("R10");
        check("R10 irq raised", {31'd0, irq}, 32'd1);

        // R6: sticky through high readings.
        strobe_a({16'hFFFF, 8'h00}, "R6");
        check("R6 still set", {29'd0, flags}, 32'd1);
        do_clear(3'b001);
        check("R7 cleared", {29'd0, flags}, 32'd0);

        // R3 / R4: length 3, one short, a break, then a full run.
        len = 8'd3;
        strobe_a({16'h1000, 8'h00}, "R3");
        strobe_a({16'h1000, 8'h00}, "R3");
        check("R3 not yet", {29'd0, flags}, 32'd0);
        strobe_a({16'h5000, 8'h00}, "R4");
        strobe_a({16'h1000, 8'h00}, "R4");
        strobe_a({16'h1000, 8'h00}, "R4");
        check("R4 run restarted", {29'd0, flags}, 32'd0);
        strobe_a({16'h1000, 8'h00}, "R3");
        check("R3 set at length", {29'd0, flags}, 32'd1);

        // R9: clear mid-run does not re-arm.
        do_clear(3'b001);
        strobe_a({16'h1000, 8'h00}, "R9");
        strobe_a({16'h1000, 8'h00}, "R9");
        strobe_a({16'h1000, 8'h00}, "R9");
        check("R9 no re-set", {29'd0, flags}, 32'd0);

        // R8: clear and detection on the same edge.
        len = 8'd1;
        strobe_a({16'h5000, 8'h00}, "R8");
        rms_a = {16'h1000, 8'h00}; strobe = 3'b001; clr = 1'b1; mask = 3'b001;
        tick("R8"); idle_inputs();
        check("R8 set wins", {29'd0, flags}, 32'd1);
        do_clear(3'b111);

        // R5: length zero never detects.
        len = 8'd0;
        for (int i = 0; i < 6; i++) begin
            rms_a = 24'h0; rms_b = 24'h0; rms_c = 24'h0; strobe = 3'b111;
            tick("R5");
        end
        idle_inputs();
        check("R5 no flags", {29'd0, flags}, 32'd0);

        // R11: random mix against the model.
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) len = 8'($urandom_range(0, 4));
            strobe = 3'($urandom_range(0, 7));
            rms_a = {16'(thr + 16'($urandom_range(0, 3)) - 16'd2), 8'($urandom)};
            rms_b = {16'(thr + 16'($urandom_range(0, 3)) - 16'd2), 8'($urandom)};
            rms_c = {16'(thr + 16'($urandom_range(0, 3)) - 16'd2), 8'($urandom)};
            clr  = ($urandom_range(0, 9) == 0);
            mask = 3'($urandom_range(0, 7));
            en   = 3'($urandom_range(0, 7));
            tick("R11");
        end
        idle_inputs();
        tick("R11");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule